// File: doc/BRIEF.md
# SDRAM Configuration and Bank Decoder

This block is the programming front end of a four-bank memory controller. Software reaches its internal registers through two outer ports: one holds an index, the other is a data window onto the register that index selects. Behind the window sit two error status registers, an error address, a configuration register and its read-only status companion. There are also a refresh timer, a power management register, four bank descriptors, a timing register, an ECC configuration register and an ECC error status register. Each register applies its own write mask, and some of them force bits.

The four bank descriptors each hold a base address, a size code and an enable bit. The block compares a physical address against the active banks and reports whether it hits, and which bank it hits. A bank is active only when its own enable bit is set and the controller enable bit in the configuration register is also set. A level interrupt output follows the ECC error status register: it is high whenever that register holds a nonzero value.

Top module: `sdram_cfg_decode`

## Requirements
- R1: With `bus_port`=0 the index register is written on the clock edge of a write and is read back in full (32 bits). With `bus_port`=1, `bus_rdata` shows the register the index selects in the same cycle.
- R2: After reset the index is 0, and the error, error address, ECC and status registers are 0. Configuration reads 0x00800000, refresh 0x05F00000 and power management 0x07C00000, all banks read 0, and `bank_hit` is 0.
- R3: Writes to the status register (index 0x24) are ignored. The error status registers (0x00, 0x08) are write-one-to-clear. The error address register (0x10) stores the full written value.
- R4: Reads at index 0x80 (timing) and at any index without a register return 0xFFFFFFFF.
- R5: The configuration register (0x20) keeps only bits 31:21. When bit 31 goes 0→1, status bit 31 clears. When bit 31 goes 1→0, status bit 31 sets.
- R6: When configuration bit 30 changes, its new value is copied into status bit 30.
- R7: Refresh (0x30) stores value & 0x3FF80000. ECC config (0x94) stores value & 0x00F00000. ECC error status (0x98) stores value & 0xFFF0F000. Power management (0x34) stores (value & 0xF8000000) | 0x07C00000.
- R8: The bank registers at 0x40, 0x44, 0x48 and 0x4C (banks 0 to 3) store value & 0xFFDEE001. In each, bit 0 is the enable, bits 31:23 are the base address and bits 19:17 are a size code n giving 4 MiB << n.
- R9: `bank_hit` is 1 only if `phys_addr` lies in [base, base+size) of a bank whose enable bit is set while configuration bit 31 is set. This holds for banks that reach the top of the 32-bit space. `bank_idx` gives that bank.
- R10: When banks overlap, the lowest-numbered one is reported. A bank with size code 7 never hits.
- R11: `ecc_irq` rises after a write that makes ECC error status nonzero from zero. It falls after a write that makes it zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_port | input | 1 | 0 selects the index register, 1 the data window |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected port, combinational |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 1 | Address falls in an active bank |
| bank_idx | output | 2 | Index of the bank that was hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The hardest case to reach is the decoder's edge behaviour. That covers a bank whose end passes the top of the address space, overlapping banks, an invalid size code, and the global enable masking banks that are already programmed. All of these can only be set up through the indirect index/data pair. The bench programs overlapping descriptors before the controller is enabled, then probes addresses on both sides of each bank limit. It then turns banks and the global enable off one at a time, so that priority falls through to the next bank and finally to a miss. The status mirror is checked along the way across every enable transition.

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode #(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_port,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [AW-1:0]         phys_addr,
  output logic                  bank_hit,
  output logic [$clog2(NB)-1:0] bank_idx,
  output logic                  ecc_irq
);
  localparam int IW = $clog2(NB);
  localparam logic [31:0] BANK_MASK = 32'hFFDEE001;

  logic [31:0] idx_q, esr0_q, esr1_q, ear_q, cfg_q, stat_q;
  logic [31:0] rtr_q, pmit_q, ecfg_q, eesr_q;
  logic [31:0] bank_q [NB];
  logic [NB-1:0] bank_en;

  wire data_wr = bus_we & bus_port;
  wire [31:0] cfg_new = bus_wdata & 32'hFFE00000;
  wire [31:0] eesr_new = bus_wdata & 32'hFFF0F000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      esr0_q <= '0;
      esr1_q <= '0;
      ear_q  <= '0;
      cfg_q  <= 32'h0080_0000;
      stat_q <= '0;
      rtr_q  <= 32'h05F0_0000;
      pmit_q <= 32'h07C0_0000;
      ecfg_q <= '0;
      eesr_q <= '0;
      ecc_irq <= 1'b0;
      for (int i = 0; i < NB; i++) bank_q[i] <= '0;
    end else if (bus_we && !bus_port) begin
      idx_q <= bus_wdata;
    end else if (data_wr) begin
      case (idx_q)
        32'h00: esr0_q <= esr0_q & ~bus_wdata;
        32'h08: esr1_q <= esr1_q & ~bus_wdata;
        32'h10: ear_q  <= bus_wdata;
        32'h20: begin
          cfg_q <= cfg_new;
          if (cfg_new[31] != cfg_q[31]) stat_q[31] <= ~cfg_new[31];
          if (cfg_new[30] != cfg_q[30]) stat_q[30] <= cfg_new[30];
        end
        32'h30: rtr_q  <= bus_wdata & 32'h3FF80000;
        32'h34: pmit_q <= (bus_wdata & 32'hF8000000) | 32'h07C00000;
        32'h94: ecfg_q <= bus_wdata & 32'h00F00000;
        32'h98: begin
          eesr_q  <= eesr_new;
          ecc_irq <= (eesr_new != 32'h0);
        end
        default: begin
          for (int i = 0; i < NB; i++)
            if (idx_q == 32'h40 + 32'(4 * i)) bank_q[i] <= bus_wdata & BANK_MASK;
        end
      endcase
    end
  end

  always_comb begin
    if (!bus_port) bus_rdata = idx_q;
    else begin
      case (idx_q)
        32'h00: bus_rdata = esr0_q;
        32'h08: bus_rdata = esr1_q;
        32'h10: bus_rdata = ear_q;
        32'h20: bus_rdata = cfg_q;
        32'h24: bus_rdata = stat_q;
        32'h30: bus_rdata = rtr_q;
        32'h34: bus_rdata = pmit_q;
        32'h94: bus_rdata = ecfg_q;
        32'h98: bus_rdata = eesr_q;
        default: begin
          bus_rdata = 32'hFFFF_FFFF;
          for (int i = 0; i < NB; i++)
            if (idx_q == 32'h40 + 32'(4 * i)) bus_rdata = bank_q[i];
        end
      endcase
    end
  end

  always_comb begin
    bank_hit = 1'b0;
    bank_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      logic [2:0]  code;
      logic [32:0] base, lim;
      code = bank_q[i][19:17];
      base = {1'b0, bank_q[i][31:23], 23'b0};
      lim  = base + (33'd1 << (22 + code));
      if (bank_en[i] && cfg_q[31] && code != 3'd7 &&
          {1'b0, phys_addr} >= base && {1'b0, phys_addr} < lim) begin
        bank_hit = 1'b1;
        bank_idx = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_en
    assign bank_en[g] = bank_q[g][0];
  end
endmodule

module sdram_cfg_decode_chk #(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_port,
  input logic                  bus_we,
  input logic [31:0]           bus_rdata,
  input logic [31:0]           idx_q,
  input logic                  cfg_en,
  input logic                  stat_dis,
  input logic [NB-1:0]         bank_en,
  input logic                  bank_hit,
  input logic [$clog2(NB)-1:0] bank_idx,
  input logic                  ecc_irq
);
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_port) |=> $stable(idx_q));
  // R4
  timing_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_port && idx_q == 32'h80) |-> bus_rdata == 32'hFFFF_FFFF);
  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en) |-> !stat_dis);
  // R5
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_en) |-> stat_dis);
  // R9
  no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !bank_hit);
  // R9
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit |-> bank_en[bank_idx]);
  // R11
  irq_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ecc_irq) || $fell(ecc_irq)) |-> $past(bus_we && bus_port && idx_q == 32'h98));
endmodule

bind sdram_cfg_decode sdram_cfg_decode_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .idx_q(idx_q), .cfg_en(cfg_q[31]),
  .stat_dis(stat_q[31]), .bank_en(bank_en), .bank_hit(bank_hit),
  .bank_idx(bank_idx), .ecc_irq(ecc_irq)
);

// File: tb/sdram_cfg_decode_tb.sv
module sdram_cfg_decode_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_port = 0, bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, phys_addr = 0;
  logic bank_hit, ecc_irq;
  logic [1:0] bank_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cfg_decode dut_i (
    .clk(clk), .rst_n(rst_n), .bus_port(bus_port), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_addr(phys_addr),
    .bank_hit(bank_hit), .bank_idx(bank_idx), .ecc_irq(ecc_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic p, logic [31:0] d);
    @(negedge clk);
    bus_port = p; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic wreg(logic [31:0] a, logic [31:0] d);
    wr(0, a);
    wr(1, d);
  endtask

  task automatic rreg(logic [31:0] a, output logic [31:0] d);
    wr(0, a);
    bus_port = 1;
    #1 d = bus_rdata;
  endtask

  task automatic probe(string req, logic [31:0] a, logic hit, logic [1:0] bi);
    phys_addr = a;
    #1;
    chk(req, {31'b0, bank_hit}, {31'b0, hit});
    if (hit) chk(req, {30'b0, bank_idx}, {30'b0, bi});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_port = 0; #1;
    chk("R2 idx", bus_rdata, 0);
    rreg(32'h00, d); chk("R2 esr0", d, 0);
    rreg(32'h10, d); chk("R2 ear", d, 0);
    rreg(32'h20, d); chk("R2 cfg", d, 32'h00800000);
    rreg(32'h24, d); chk("R2 stat", d, 0);
    rreg(32'h30, d); chk("R2 rtr", d, 32'h05F00000);
    rreg(32'h34, d); chk("R2 pmit", d, 32'h07C00000);
    rreg(32'h98, d); chk("R2 eesr", d, 0);
    for (int i = 0; i < 4; i++) begin
      rreg(32'h40 + 4 * i, d); chk("R2 bank", d, 0);
    end
    chk("R2 hit", {31'b0, bank_hit}, 0);
  endtask

  task automatic t_index;
    wr(0, 32'hABCD0024);
    bus_port = 0; #1;
    chk("R1 idx readback", bus_rdata, 32'hABCD0024);
    bus_port = 1; #1;
    chk("R1 unmatched window", bus_rdata, 32'hFFFFFFFF);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    wreg(32'h24, 32'hFFFFFFFF); rreg(32'h24, d); chk("R3 stat ro", d, 0);
    wreg(32'h00, 32'hFFFFFFFF); rreg(32'h00, d); chk("R3 esr0 w1c", d, 0);
    wreg(32'h08, 32'hFFFFFFFF); rreg(32'h08, d); chk("R3 esr1 w1c", d, 0);
    wreg(32'h10, 32'h12345678); rreg(32'h10, d); chk("R3 ear", d, 32'h12345678);
    wreg(32'h80, 32'h0); rreg(32'h80, d); chk("R4 timing", d, 32'hFFFFFFFF);
    rreg(32'h04, d); chk("R4 unknown 04", d, 32'hFFFFFFFF);
    rreg(32'h50, d); chk("R4 unknown 50", d, 32'hFFFFFFFF);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wreg(32'h30, 32'hFFFFFFFF); rreg(32'h30, d); chk("R7 rtr", d, 32'h3FF80000);
    wreg(32'h34, 32'hFFFFFFFF); rreg(32'h34, d); chk("R7 pmit ones", d, 32'hFFC00000);
    wreg(32'h34, 32'h0); rreg(32'h34, d); chk("R7 pmit zero", d, 32'h07C00000);
    wreg(32'h94, 32'hFFFFFFFF); rreg(32'h94, d); chk("R7 ecfg", d, 32'h00F00000);
    wreg(32'h40, 32'hFFFFFFFF); rreg(32'h40, d); chk("R8 bank mask", d, 32'hFFDEE001);
    wreg(32'h40, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wreg(32'h98, 32'h000F0FFF); rreg(32'h98, d);
    chk("R7 eesr masked", d, 0);
    chk("R11 irq low", {31'b0, ecc_irq}, 0);
    wreg(32'h98, 32'h00001000); rreg(32'h98, d);
    chk("R7 eesr", d, 32'h00001000);
    chk("R11 irq rise", {31'b0, ecc_irq}, 1);
    wreg(32'h98, 32'h00000FFF);
    chk("R11 irq fall", {31'b0, ecc_irq}, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wreg(32'h20, 32'hFFFFFFFF); rreg(32'h20, d); chk("R5 cfg mask", d, 32'hFFE00000);
    rreg(32'h24, d); chk("R6 stat on", d, 32'h40000000);
    wreg(32'h20, 32'h0); rreg(32'h24, d); chk("R5 stat off", d, 32'h80000000);
    wreg(32'h20, 32'h80000000); rreg(32'h24, d); chk("R5 stat reenable", d, 32'h00000000);
    wreg(32'h20, 32'hC0000000); rreg(32'h24, d); chk("R6 bit30 set", d, 32'h40000000);
    wreg(32'h20, 32'h0); rreg(32'h24, d); chk("R6 both clear", d, 32'h80000000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wreg(32'h40, 32'h00040001);
    wreg(32'h44, 32'h00800001);
    wreg(32'h48, 32'h100E0001);
    wreg(32'h4C, 32'h200C0001);
    probe("R9 disabled ctrl", 32'h00900000, 0, 0);
    wreg(32'h20, 32'h80000000);
    probe("R10 overlap low wins", 32'h00900000, 1, 0);
    probe("R9 bank0 start", 32'h00000000, 1, 0);
    probe("R9 bank0 end miss", 32'h01000000, 0, 0);
    probe("R10 size7 miss", 32'h10000000, 0, 0);
    probe("R9 bank3 last", 32'h2FFFFFFC, 1, 3);
    probe("R9 bank3 past", 32'h30000000, 0, 0);
    wreg(32'h40, 32'h00040000);
    probe("R10 fallthrough", 32'h00900000, 1, 1);
    wreg(32'h4C, 32'hF80C0001);
    probe("R9 top of space", 32'hFFFFFFFC, 1, 3);
    probe("R9 below top", 32'hF7FFFFFC, 0, 0);
    wreg(32'h20, 32'h0);
    probe("R9 global off", 32'h00900000, 0, 0);
    rreg(32'h24, d); chk("R5 stat after off", d, 32'h80000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_index();
    t_misc();
    t_masks();
    t_irq();
    t_cfg();
    t_decode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule